// File: doc/BRIEF.md
# Interval Down-Counter Timer

This block is a 32-bit down-counter that software loads through a small register bus. It steps down by one on every cycle where the time-base tick input is high. Each load of the counter also copies the value into a reload register. Software cannot read that reload register. When the count steps down from 1, the block records a timer event. If auto-reload is on, the counter is refilled from the reload register in that same cycle. If auto-reload is off, the counter rests at zero until software loads it again.

Every event sets a sticky status flag. Software clears that flag by writing a mask in which a 1 clears the flag. The level interrupt output follows the flag, but only while both the local interrupt-enable bit and the global interrupt-enable input are high.

There are three word addresses. Address 0 is the counter. Address 1 is the control register. Address 2 is the status register. Reads are combinational from the current address.

Top module: `intv_timer`

## Requirements
- R1: After reset, the counter (address 0), control (address 1) and status (address 2) all read 0, the reload register is 0, and `irq` is low.
- R2: A write to address 0 loads both the counter and the reload register with the write data. Reads of address 0 return the live count.
- R3: In a cycle with `tick_en` high and a count above 1, the count drops by one. Without a tick, the count holds its value.
- R4: A timer event happens exactly when `tick_en` is high and the count is 1. With auto-reload off, the count becomes 0 and then holds 0 through any number of ticks until address 0 is written.
- R5: With auto-reload on (control bit 1), an event loads the count from the reload register in the same cycle, so the count never reads 0.
- R6: Every event sets status bit 0, and the bit stays set until software clears it.
- R7: Writing to address 2 acts as a clear mask: a 1 in bit 0 clears the status bit and a 0 leaves it unchanged. If an event occurs in the same cycle as a clear, the bit stays set.
- R8: `irq` is high exactly when status bit 0, control bit 0 (interrupt enable) and the `glob_ie` input are all 1.
- R9: A software write of 0 to the counter never sets the status bit by itself.
- R10: If a counter write and a tick fall in the same cycle, the written value becomes the count. If that tick met a count of 1, the event still sets the status bit.
- R11: Control bit 0 is the interrupt enable and bit 1 is auto-reload, and both read back. All other control and status bits read 0, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Word address: 0 counter, 1 control, 2 status |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| tick_en | input | 1 | Time-base tick, one decrement per high cycle |
| glob_ie | input | 1 | Global interrupt enable |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest cases to reach are the ones where a software write lands in the same cycle as the tick that takes the count from 1. One case is a counter write that overrides the reload while the event still sets the status flag. The other is a status clear that collides with a new event. Directed sequences first count down to exactly 1 and then issue that write together with a tick. Random phases keep loaded values small, so these collisions also happen by chance many times over.

// File: rtl/intv_pkg.sv
package intv_pkg;
  localparam int CNT_W  = 32;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CNT = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTL = 2'd1;
  localparam logic [ADDR_W-1:0] A_STS = 2'd2;

  // Next count for a tick cycle with no software write.
  function automatic logic [CNT_W-1:0] tick_next(
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] rel,
    input logic             arl
  );
    if (cur == '0)
      return '0;
    else if (cur == CNT_W'(1))
      return arl ? rel : '0;
    else
      return cur - CNT_W'(1);
  endfunction

  function automatic logic is_event(
    input logic [CNT_W-1:0] cur,
    input logic             tick
  );
    return tick && (cur == CNT_W'(1));
  endfunction
endpackage

// File: rtl/intv_count.sv
module intv_count
  import intv_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         wr_cnt,
  input  logic [W-1:0] wdata,
  input  logic         arl,
  output logic [W-1:0] cnt,
  output logic         evt
);
  logic [W-1:0] rel_q;
  logic [W-1:0] cnt_nx;

  assign evt = tick_en && (cnt == W'(1));

  always_comb begin
    cnt_nx = cnt;
    if (wr_cnt)
      cnt_nx = wdata;
    else if (tick_en)
      cnt_nx = (cnt == '0) ? '0 : ((cnt == W'(1)) ? (arl ? rel_q : '0) : cnt - W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      rel_q <= '0;
    end else begin
      cnt <= cnt_nx;
      if (wr_cnt) rel_q <= wdata;
    end
  end

  // R2: a counter write shows up as the count on the next cycle
  p_wr_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt == $past(wdata));
  // R3: an idle cycle leaves the count untouched
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cnt && !tick_en) |=> $stable(cnt));
  // R4: a zero count with no write stays zero
  p_zero_rest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cnt && cnt == '0) |=> cnt == '0);
  // R5: auto-reload never exposes zero after a valid load
  p_no_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && arl && !wr_cnt) |=> cnt != '0);
endmodule

// File: rtl/intv_regs.sv
module intv_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctl,
  input  logic [1:0] ctl_wdata,
  input  logic wr_sts,
  input  logic sts_clr_bit,
  input  logic evt,
  input  logic glob_ie,
  output logic ie,
  output logic arl,
  output logic status,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie     <= 1'b0;
      arl    <= 1'b0;
      status <= 1'b0;
    end else begin
      if (wr_ctl) begin
        ie  <= ctl_wdata[0];
        arl <= ctl_wdata[1];
      end
      if (evt)
        status <= 1'b1;
      else if (wr_sts && sts_clr_bit)
        status <= 1'b0;
    end
  end

  assign irq = status & ie & glob_ie;

  // R6: the status bit only rises after an event
  p_status_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status) |-> $past(evt));
  // R6/R7: an event always leaves the status set
  p_evt_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> status);
  // R7: a zero mask bit never clears the status
  p_mask_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !(wr_sts && sts_clr_bit)) |=> status);
endmodule

// File: rtl/intv_timer.sv
module intv_timer
  import intv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              tick_en,
  input  logic              glob_ie,
  output logic              irq
);
  logic             wr_cnt, wr_ctl, wr_sts;
  logic [CNT_W-1:0] cnt;
  logic             evt, ie, arl, status;

  assign wr_cnt = bus_wr && (bus_addr == A_CNT);
  assign wr_ctl = bus_wr && (bus_addr == A_CTL);
  assign wr_sts = bus_wr && (bus_addr == A_STS);

  intv_count #(.W(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .wr_cnt  (wr_cnt),
    .wdata   (bus_wdata),
    .arl     (arl),
    .cnt     (cnt),
    .evt     (evt)
  );

  intv_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_ctl      (wr_ctl),
    .ctl_wdata   (bus_wdata[1:0]),
    .wr_sts      (wr_sts),
    .sts_clr_bit (bus_wdata[0]),
    .evt         (evt),
    .glob_ie     (glob_ie),
    .ie          (ie),
    .arl         (arl),
    .status      (status),
    .irq         (irq)
  );

  always_comb begin
    unique case (bus_addr)
      A_CNT:   bus_rdata = cnt;
      A_CTL:   bus_rdata = {{(CNT_W-2){1'b0}}, arl, ie};
      A_STS:   bus_rdata = {{(CNT_W-1){1'b0}}, status};
      default: bus_rdata = '0;
    endcase
  end

  // R9: a write of zero alone never raises the status
  p_zero_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt && bus_wdata == '0 && !evt && !status) |=> !status);
  // R10: write wins over a colliding tick
  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt && tick_en) |=> cnt == $past(bus_wdata));
endmodule

// File: tb/intv_timer_bench.sv
module intv_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_en = 1'b0;
  logic        glob_ie = 1'b0;
  logic        irq;

  int checks = 0;
  int fails = 0;

  // reference state
  logic [31:0] m_cnt = '0, m_rel = '0;
  logic        m_ie = 1'b0, m_arl = 1'b0, m_st = 1'b0;

  always #5 clk = ~clk;

  intv_timer u_intv_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en),
    .glob_ie(glob_ie), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference count after one cycle, written independently of the design
  function automatic logic [31:0] ref_cnt(input logic [31:0] c, input logic [31:0] r,
                                          input logic a, input logic t,
                                          input logic w, input logic [31:0] d);
    if (w) return d;
    if (!t || c == 0) return c;
    if (c > 1) return c - 1;
    return a ? r : 32'd0;
  endfunction

  // peek all registers, called just after a falling edge
  task automatic peek(input string req);
    bus_wr = 1'b0; tick_en = 1'b0;
    bus_addr = 2'd0; #1 chk({req, " cnt"}, bus_rdata, m_cnt);
    bus_addr = 2'd1; #1 chk({req, " ctl R11"}, bus_rdata, {30'd0, m_arl, m_ie});
    bus_addr = 2'd2; #1 chk({req, " sts"}, bus_rdata, {31'd0, m_st});
    bus_addr = 2'd3; #1 chk({req, " addr3 R11"}, bus_rdata, 32'd0);
    chk({req, " irq R8"}, {31'd0, irq}, {31'd0, m_st & m_ie & glob_ie});
  endtask

  // one clock cycle with the given stimulus; returns just after the next falling edge
  task automatic step(input logic w, input logic [1:0] a, input logic [31:0] d,
                      input logic t, input logic g);
    logic ev;
    bus_wr = w; bus_addr = a; bus_wdata = d; tick_en = t; glob_ie = g;
    @(posedge clk);
    ev = t && (m_cnt == 32'd1);
    m_cnt = ref_cnt(m_cnt, m_rel, m_arl, t, w && a == 2'd0, d);
    if (w && a == 2'd0) m_rel = d;
    if (w && a == 2'd1) begin m_ie = d[0]; m_arl = d[1]; end
    if (ev) m_st = 1'b1;
    else if (w && a == 2'd2 && d[0]) m_st = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    peek("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    peek("R1 after reset");

    // R2/R3: load and count
    step(1, 0, 32'd5, 0, 1); peek("R2 load");
    step(0, 0, 0, 1, 1); step(0, 0, 0, 1, 1); step(0, 0, 0, 1, 1);
    peek("R3 three ticks");
    step(0, 0, 0, 0, 1); step(0, 0, 0, 0, 1); peek("R3 no tick hold");
    // R4: reach 1, tick to 0, rest at 0
    step(0, 0, 0, 1, 1); peek("R4 at one");
    step(1, 1, 32'd1, 0, 1);              // enable irq
    step(0, 0, 0, 1, 1); peek("R4 R6 event to zero");
    step(0, 0, 0, 1, 1); step(0, 0, 0, 1, 1); peek("R4 zero rests");
    // R8 gating
    step(0, 0, 0, 0, 0); peek("R8 global off");
    step(1, 1, 32'd0, 0, 1); peek("R8 local off");
    // R7: mask of 0 keeps, 1 clears
    step(1, 2, 32'hFFFF_FFFE, 0, 1); peek("R7 zero mask keeps");
    step(1, 2, 32'd1, 0, 1); peek("R7 one clears");
    // R5: auto-reload
    step(1, 1, 32'd3, 0, 1);
    step(1, 0, 32'd3, 0, 1);
    step(0, 0, 0, 1, 1); step(0, 0, 0, 1, 1); peek("R5 at one");
    step(0, 0, 0, 1, 1); peek("R5 reload no zero");
    // R7: clear colliding with event keeps status set
    step(1, 2, 32'd1, 0, 1);
    step(0, 0, 0, 1, 1); step(0, 0, 0, 1, 1);
    step(1, 2, 32'd1, 1, 1); peek("R7 clear vs event");
    // R9: write zero alone
    step(1, 2, 32'd1, 0, 1);
    step(1, 0, 32'd0, 0, 1); peek("R9 zero write");
    // R10: write 0 while tick meets count of 1
    step(1, 0, 32'd2, 0, 1); step(0, 0, 0, 1, 1);
    step(1, 0, 32'd0, 1, 1); peek("R10 write wins event kept");
    step(1, 2, 32'd1, 0, 1);
    step(1, 0, 32'd1, 0, 1);
    step(1, 0, 32'd7, 1, 1); peek("R10 write 7 over event");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic w; logic [1:0] a; logic [31:0] d;
      w = ($urandom % 8) == 0;
      a = 2'($urandom % 4);
      d = ($urandom % 4 == 0) ? $urandom : 32'($urandom % 7);
      step(w, a, d, ($urandom % 3) != 0, ($urandom % 4) != 0);
      peek("R2 R3 R4 R5 R6 R7 R8 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule